// File: doc/BRIEF.md
# SPI Master with Per-Word Chip-Select Hold

This block is a register-mapped SPI master. Software writes one 32-bit transmit word for each character. The word carries the character, the number of the chip-select line to use, and a hold flag. The controller pulls the selected chip-select line low and waits a programmable setup time. It then clocks the character out on MOSI and captures MISO on the mid-bit clock edge. The received character goes to a receive register, which also reports two status flags.

A single-entry holding stage sits in front of the shifter, so software can queue the next word while the current one is on the wire. If the current word has its hold flag set, the queued word starts at once after the last bit period. There is no release and no setup delay, and chip-select stays low across the boundary. Several settings are programmable:
- character length, clock divisor, clock phase, clock polarity and bit order;
- the chip-select setup and release delays, counted in system clock cycles;
- the idle level of each chip-select line.

A run/reset bit and a mode register decide whether queued words may start.

Top module: `spi_hold_master`

## Requirements
- R1: When rst_ni is released, every chip-select line is high, sclk_o and mosi_o are 0, and reading offset 6 returns bit 31 (receive empty) = 1 and bit 29 (transmit full) = 0.
- R2: The transmit word is written at offset 5. Bits [15:0] hold the character, which is sent using its low L bits. Bits starting at 16 give the chip-select number, and bit 28 is the hold flag.
- R3: The format register is at offset 2. Bits [4:0] give the length L; 0, or any value above MAX_CHAR, means MAX_CHAR. Bits [15:8] give the divisor P, and one bit period lasts P+1 cycles, with P=0 treated as 1. Bit 16 is the phase, bit 17 is the polarity (the idle level of sclk_o), and bit 20 set sends the LSB first (0 sends the MSB first). Phase 0 makes the first clock edge at mid-bit; phase 1 makes it at the start of the bit. MISO is always captured on the mid-bit edge.
- R4: The delay register is at offset 3. Bits [31:24] give the number of cycles from chip-select assertion to the first bit period, and bits [23:16] the number of cycles from the end of the last bit period to release. For one word, chip-select is low for setup + L*(P+1) + release cycles.
- R5: The received character is readable in bits [15:0] at offset 6. Bit 31 clears when a word completes and is set again by a read of offset 6.
- R6: Bit 29 at offset 6 is 1 while the holding stage holds a word. A transmit write made while it is 1 is ignored.
- R7: When a word with the hold flag set completes and a word is queued, the queued word's first bit period starts in the next cycle, and chip-select stays low without a break.
- R8: When a word with the hold flag set completes and nothing is queued, chip-select stays low indefinitely. It is released only through the release delay after a later word that has the flag clear.
- R9: During a transfer, only the line given by the chip-select number is driven low. All other lines stay at their idle level.
- R10: The idle-level register is at offset 4. Bit i is the level of line i when that line is not in use. Its reset value is all ones.
- R11: Bit 0 at offset 0 is 0 after reset, and while it is 0 the block is held in reset. In that state the shifter is idle, the holding stage and the receive register are cleared, and transmit writes are ignored.
- R12: A queued word starts only while bit 0 (master) and bit 24 (enable) at offset 1 are both 1. Until then it waits in the holding stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (a read of offset 6 sets receive empty) |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from reg_addr_i |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | NUM_CS | Chip-select lines, active low |

## Verification
Register writes take effect on the clock edge that samples the strobe. A queued word is taken by the shifter one edge later, and chip-select drops together with that edge. The first bit period starts exactly `setup` cycles after that. Mid-bit clock edges come ceil((P+1)/2) cycles into each bit period, and the receive register updates on the edge that ends the last bit period. The bench drives inputs and samples outputs on falling edges. It counts falling edges spent with a line low and falling edges from assertion to the first clock edge, and compares these with the setup + L*(P+1) + release formula. It changes MISO only after each capture edge, and reads the receive register only after chip-select has risen, or after a fixed wait when the hold flag keeps the line low.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  localparam int PRE_W = 8;
  localparam int LEN_W = 5;

  localparam logic [2:0] OFS_RUNCTL = 3'd0;
  localparam logic [2:0] OFS_MODE   = 3'd1;
  localparam logic [2:0] OFS_FMT    = 3'd2;
  localparam logic [2:0] OFS_DLY    = 3'd3;
  localparam logic [2:0] OFS_CSIDLE = 3'd4;
  localparam logic [2:0] OFS_TX     = 3'd5;
  localparam logic [2:0] OFS_RX     = 3'd6;

  localparam int TX_CS_LSB   = 16;
  localparam int TX_HOLD_BIT = 28;
  localparam int RX_EMPTY    = 31;
  localparam int RX_FULL     = 29;
  localparam int FMT_PHA     = 16;
  localparam int FMT_POL     = 17;
  localparam int FMT_DIR     = 20;
  localparam int MODE_MST    = 0;
  localparam int MODE_ICLK   = 1;
  localparam int MODE_EN     = 24;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_SHIFT, ST_TAIL, ST_HELD
  } eng_st_e;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [PRE_W-1:0] presc;
    logic             cpha;
    logic             cpol;
    logic             lsb_first;
  } fmt_t;
endpackage

// File: rtl/spi_hold_regs.sv
module spi_hold_regs
  import spi_hold_pkg::*;
#(
  parameter int NUM_CS   = 4,
  parameter int MAX_CHAR = 16,
  localparam int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic                re_i,
  input  logic [2:0]          addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic                srst_o,
  output logic                run_o,
  output fmt_t                fmt_o,
  output logic [7:0]          c2t_o,
  output logic [7:0]          t2c_o,
  output logic [NUM_CS-1:0]   csdef_o,
  output logic                pend_vld_o,
  output logic [MAX_CHAR-1:0] pend_data_o,
  output logic [CSW-1:0]      pend_cs_o,
  output logic                pend_hold_o,
  input  logic                take_i,
  input  logic                done_i,
  input  logic [MAX_CHAR-1:0] rx_data_i
);
  logic                run_en_q, mst_q, iclk_q, ena_q;
  logic [LEN_W-1:0]    len_raw_q;
  logic [PRE_W-1:0]    presc_q;
  logic                cpha_q, cpol_q, lsb_q;
  logic [7:0]          c2t_q, t2c_q;
  logic [NUM_CS-1:0]   csdef_q;
  logic                pend_vld_q;
  logic [MAX_CHAR-1:0] pend_data_q;
  logic [CSW-1:0]      pend_cs_q;
  logic                pend_hold_q;
  logic [MAX_CHAR-1:0] rx_data_q;
  logic                rx_empty_q;
  logic                srst;
  logic                tx_wr, rx_rd;
  wire                 unused_wdata = ^wdata_i;

  assign srst  = !run_en_q;
  assign tx_wr = we_i && addr_i == OFS_TX && !srst && !pend_vld_q;
  assign rx_rd = re_i && addr_i == OFS_RX;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_en_q  <= 1'b0;
      mst_q     <= 1'b0;
      iclk_q    <= 1'b0;
      ena_q     <= 1'b0;
      len_raw_q <= '0;
      presc_q   <= '0;
      cpha_q    <= 1'b0;
      cpol_q    <= 1'b0;
      lsb_q     <= 1'b0;
      c2t_q     <= '0;
      t2c_q     <= '0;
      csdef_q   <= '1;
    end else if (we_i) begin
      unique case (addr_i)
        OFS_RUNCTL: run_en_q <= wdata_i[0];
        OFS_MODE: begin
          mst_q  <= wdata_i[MODE_MST];
          iclk_q <= wdata_i[MODE_ICLK];
          ena_q  <= wdata_i[MODE_EN];
        end
        OFS_FMT: begin
          len_raw_q <= wdata_i[LEN_W-1:0];
          presc_q   <= wdata_i[8 +: PRE_W];
          cpha_q    <= wdata_i[FMT_PHA];
          cpol_q    <= wdata_i[FMT_POL];
          lsb_q     <= wdata_i[FMT_DIR];
        end
        OFS_DLY: begin
          c2t_q <= wdata_i[31:24];
          t2c_q <= wdata_i[23:16];
        end
        OFS_CSIDLE: csdef_q <= wdata_i[NUM_CS-1:0];
        default: ;
      endcase
    end
  end

  // single-entry holding stage in front of the shifter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld_q  <= 1'b0;
      pend_data_q <= '0;
      pend_cs_q   <= '0;
      pend_hold_q <= 1'b0;
    end else if (srst) begin
      pend_vld_q <= 1'b0;
    end else if (tx_wr) begin
      pend_vld_q  <= 1'b1;
      pend_data_q <= wdata_i[MAX_CHAR-1:0];
      pend_cs_q   <= wdata_i[TX_CS_LSB +: CSW];
      pend_hold_q <= wdata_i[TX_HOLD_BIT];
    end else if (take_i) begin
      pend_vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_q  <= '0;
      rx_empty_q <= 1'b1;
    end else if (srst) begin
      rx_data_q  <= '0;
      rx_empty_q <= 1'b1;
    end else if (done_i) begin
      rx_data_q  <= rx_data_i;
      rx_empty_q <= 1'b0;
    end else if (rx_rd) begin
      rx_empty_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_RUNCTL: rdata_o[0] = run_en_q;
      OFS_MODE: begin
        rdata_o[MODE_MST]  = mst_q;
        rdata_o[MODE_ICLK] = iclk_q;
        rdata_o[MODE_EN]   = ena_q;
      end
      OFS_FMT: begin
        rdata_o[LEN_W-1:0]  = len_raw_q;
        rdata_o[8 +: PRE_W] = presc_q;
        rdata_o[FMT_PHA]    = cpha_q;
        rdata_o[FMT_POL]    = cpol_q;
        rdata_o[FMT_DIR]    = lsb_q;
      end
      OFS_DLY:    rdata_o = {c2t_q, t2c_q, 16'h0};
      OFS_CSIDLE: rdata_o[NUM_CS-1:0] = csdef_q;
      OFS_RX: begin
        rdata_o[MAX_CHAR-1:0] = rx_data_q;
        rdata_o[RX_EMPTY]     = rx_empty_q;
        rdata_o[RX_FULL]      = pend_vld_q;
      end
      default: ;
    endcase
  end

  assign srst_o          = srst;
  assign run_o           = run_en_q && mst_q && ena_q;
  assign fmt_o.len       = (len_raw_q == '0 || int'(len_raw_q) > MAX_CHAR)
                           ? LEN_W'(MAX_CHAR) : len_raw_q;
  assign fmt_o.presc     = presc_q;
  assign fmt_o.cpha      = cpha_q;
  assign fmt_o.cpol      = cpol_q;
  assign fmt_o.lsb_first = lsb_q;
  assign c2t_o           = c2t_q;
  assign t2c_o           = t2c_q;
  assign csdef_o         = csdef_q;
  assign pend_vld_o      = pend_vld_q;
  assign pend_data_o     = pend_data_q;
  assign pend_cs_o       = pend_cs_q;
  assign pend_hold_o     = pend_hold_q;

  // R6
  txfull_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_vld_q && !take_i && !srst) |=> (pend_vld_q && $stable(pend_data_q) && $stable(pend_cs_q)));
  // R5
  rx_post_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !srst) |=> !rx_empty_q);
endmodule

// File: rtl/spi_hold_bitclk.sv
module spi_hold_bitclk
  import spi_hold_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PRE_W-1:0] ntop_i,
  output logic             mid_o,
  output logic             last_o,
  output logic             first_half_o,
  output logic [PRE_W-1:0] pcnt_o
);
  logic [PRE_W-1:0] pcnt_q;
  logic [PRE_W:0]   h1;

  assign h1 = ({1'b0, ntop_i} + (PRE_W+1)'(2)) >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pcnt_q <= '0;
    else if (!run_i)            pcnt_q <= '0;
    else if (pcnt_q == ntop_i)  pcnt_q <= '0;
    else                        pcnt_q <= pcnt_q + 1'b1;
  end

  assign first_half_o = {1'b0, pcnt_q} < h1;
  assign mid_o        = run_i && ({1'b0, pcnt_q} == h1 - 1'b1);
  assign last_o       = run_i && (pcnt_q == ntop_i);
  assign pcnt_o       = pcnt_q;
endmodule

// File: rtl/spi_hold_engine.sv
module spi_hold_engine
  import spi_hold_pkg::*;
#(
  parameter int NUM_CS   = 4,
  parameter int MAX_CHAR = 16,
  localparam int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                srst_i,
  input  logic                run_i,
  input  fmt_t                fmt_i,
  input  logic [7:0]          c2t_i,
  input  logic [7:0]          t2c_i,
  input  logic                pend_vld_i,
  input  logic [MAX_CHAR-1:0] pend_data_i,
  input  logic [CSW-1:0]      pend_cs_i,
  input  logic                pend_hold_i,
  input  logic                miso_i,
  output logic                take_o,
  output logic                done_o,
  output logic [MAX_CHAR-1:0] rx_data_o,
  output logic                sclk_o,
  output logic                mosi_o,
  output logic                cs_act_o,
  output logic [CSW-1:0]      cs_sel_o
);
  eng_st_e             state_q;
  logic [7:0]          dcnt_q;
  logic [LEN_W-1:0]    bidx_q, len_q, pos;
  logic [MAX_CHAR-1:0] tx_q, rx_q, tx_sh;
  logic [CSW-1:0]      cs_sel_q;
  logic                hold_q, lsb_q, cpha_q;
  logic [PRE_W-1:0]    ntop_q, pcnt;
  logic                mid, last, first_half, bit_last, in_shift;

  assign in_shift = state_q == ST_SHIFT;

  spi_hold_bitclk u_bitclk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (in_shift),
    .ntop_i       (ntop_q),
    .mid_o        (mid),
    .last_o       (last),
    .first_half_o (first_half),
    .pcnt_o       (pcnt)
  );

  assign bit_last = bidx_q == len_q - 1'b1;
  assign pos      = lsb_q ? bidx_q : (len_q - 1'b1 - bidx_q);
  assign tx_sh    = tx_q >> pos;

  always_comb begin
    take_o = 1'b0;
    if (run_i && pend_vld_i && !srst_i) begin
      unique case (state_q)
        ST_IDLE, ST_HELD: take_o = 1'b1;
        ST_SHIFT:         take_o = last && bit_last && hold_q;
        default:          take_o = 1'b0;
      endcase
    end
  end

  assign done_o = last && bit_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      dcnt_q   <= '0;
      bidx_q   <= '0;
      len_q    <= LEN_W'(MAX_CHAR);
      tx_q     <= '0;
      rx_q     <= '0;
      cs_sel_q <= '0;
      hold_q   <= 1'b0;
      lsb_q    <= 1'b0;
      cpha_q   <= 1'b0;
      ntop_q   <= PRE_W'(1);
    end else if (srst_i) begin
      state_q <= ST_IDLE;
      dcnt_q  <= '0;
      bidx_q  <= '0;
    end else begin
      if (take_o) begin
        tx_q     <= pend_data_i;
        rx_q     <= '0;
        cs_sel_q <= pend_cs_i;
        hold_q   <= pend_hold_i;
        len_q    <= fmt_i.len;
        lsb_q    <= fmt_i.lsb_first;
        cpha_q   <= fmt_i.cpha;
        ntop_q   <= (fmt_i.presc == '0) ? PRE_W'(1) : fmt_i.presc;
        bidx_q   <= '0;
      end else if (mid) begin
        rx_q <= rx_q | ({{(MAX_CHAR-1){1'b0}}, miso_i} << pos);
      end
      unique case (state_q)
        ST_IDLE: if (take_o) begin
          state_q <= (c2t_i == '0) ? ST_SHIFT : ST_SETUP;
          dcnt_q  <= c2t_i - 1'b1;
        end
        ST_SETUP: begin
          if (dcnt_q == '0) state_q <= ST_SHIFT;
          else              dcnt_q  <= dcnt_q - 1'b1;
        end
        ST_SHIFT: if (last) begin
          if (!bit_last)    bidx_q  <= bidx_q + 1'b1;
          else if (take_o)  state_q <= ST_SHIFT;
          else if (hold_q)  state_q <= ST_HELD;
          else if (t2c_i == '0) state_q <= ST_IDLE;
          else begin
            state_q <= ST_TAIL;
            dcnt_q  <= t2c_i - 1'b1;
          end
        end
        ST_TAIL: begin
          if (dcnt_q == '0) state_q <= ST_IDLE;
          else              dcnt_q  <= dcnt_q - 1'b1;
        end
        ST_HELD: if (take_o) state_q <= ST_SHIFT;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rx_data_o = rx_q;
  assign sclk_o    = fmt_i.cpol ^ (in_shift && (cpha_q ? first_half : !first_half));
  assign mosi_o    = in_shift && tx_sh[0];
  assign cs_act_o  = state_q != ST_IDLE;
  assign cs_sel_o  = cs_sel_q;

  // R3
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_shift && $past(in_shift) && pcnt != '0) |-> $stable(mosi_o));
  // R7
  bidx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_shift && $past(in_shift) && pcnt != '0) |-> $stable(bidx_q));
endmodule

// File: rtl/spi_hold_csdrv.sv
module spi_hold_csdrv #(
  parameter int NUM_CS = 4,
  localparam int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              act_i,
  input  logic [CSW-1:0]    sel_i,
  input  logic [NUM_CS-1:0] csdef_i,
  output logic [NUM_CS-1:0] cs_n_o
);
  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    assign cs_n_o[i] = (act_i && sel_i == CSW'(i)) ? 1'b0 : csdef_i[i];
  end
endmodule

// File: rtl/spi_hold_master.sv
module spi_hold_master
  import spi_hold_pkg::*;
#(
  parameter int NUM_CS   = 4,
  parameter int MAX_CHAR = 16,
  localparam int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_n_o
);
  logic                srst, run, pend_vld, pend_hold, take, done, cs_act;
  fmt_t                fmt;
  logic [7:0]          c2t, t2c;
  logic [NUM_CS-1:0]   csdef;
  logic [MAX_CHAR-1:0] pend_data, rx_data;
  logic [CSW-1:0]      pend_cs, cs_sel;

  spi_hold_regs #(.NUM_CS(NUM_CS), .MAX_CHAR(MAX_CHAR)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .re_i        (reg_re_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .srst_o      (srst),
    .run_o       (run),
    .fmt_o       (fmt),
    .c2t_o       (c2t),
    .t2c_o       (t2c),
    .csdef_o     (csdef),
    .pend_vld_o  (pend_vld),
    .pend_data_o (pend_data),
    .pend_cs_o   (pend_cs),
    .pend_hold_o (pend_hold),
    .take_i      (take),
    .done_i      (done),
    .rx_data_i   (rx_data)
  );

  spi_hold_engine #(.NUM_CS(NUM_CS), .MAX_CHAR(MAX_CHAR)) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .srst_i      (srst),
    .run_i       (run),
    .fmt_i       (fmt),
    .c2t_i       (c2t),
    .t2c_i       (t2c),
    .pend_vld_i  (pend_vld),
    .pend_data_i (pend_data),
    .pend_cs_i   (pend_cs),
    .pend_hold_i (pend_hold),
    .miso_i      (miso_i),
    .take_o      (take),
    .done_o      (done),
    .rx_data_o   (rx_data),
    .sclk_o      (sclk_o),
    .mosi_o      (mosi_o),
    .cs_act_o    (cs_act),
    .cs_sel_o    (cs_sel)
  );

  spi_hold_csdrv #(.NUM_CS(NUM_CS)) u_csdrv (
    .act_i   (cs_act),
    .sel_i   (cs_sel),
    .csdef_i (csdef),
    .cs_n_o  (cs_n_o)
  );

  // R9
  one_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_n_o & csdef) <= 1);
endmodule

// File: tb/spi_hold_master_tb.sv
module spi_hold_master_tb;
  localparam int NCS = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic we = 1'b0, re = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic sclk, mosi, miso = 1'b0;
  logic [NCS-1:0] cs_n;

  always #5 clk_i = ~clk_i;

  spi_hold_master #(.NUM_CS(NCS), .MAX_CHAR(16)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_n_o(cs_n)
  );

  int vectors = 0, fails = 0;
  logic [NCS-1:0] csdef_exp = '1;
  logic t_cpol = 1'b0, t_cpha = 1'b0;
  logic rep_bits [0:63];
  logic cap_bits [0:63];
  int mon_cnt = 0, cs_low_cnt = 0, lead_cnt = 0;
  bit started = 0, edge_seen = 0;
  logic [NCS-1:0] seen_mask = '0;
  logic sclk_prev = 1'b0;

  always @(negedge clk_i) begin
    if (cs_n != csdef_exp) begin
      cs_low_cnt++;
      started = 1;
      seen_mask |= ~cs_n & csdef_exp;
      if (!edge_seen && sclk == t_cpol) lead_cnt++;
    end
    if (sclk != sclk_prev) begin
      edge_seen = 1;
      if ((sclk == 1'b1) == (t_cpol == t_cpha) && mon_cnt < 63) begin
        cap_bits[mon_cnt] = mosi;
        mon_cnt++;
        miso = rep_bits[mon_cnt];
      end
    end
    sclk_prev = sclk;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i); addr = a; wdata = d; we = 1'b1;
    @(negedge clk_i); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i); addr = a; re = 1'b1; #1 d = rdata;
    @(negedge clk_i); re = 1'b0;
  endtask

  task automatic set_fmt(input int len, input int presc, input bit pha, input bit pol, input bit lsb);
    wr(3'd2, 32'(len) | (32'(presc) << 8) | (32'(pha) << 16) | (32'(pol) << 17) | (32'(lsb) << 20));
    t_cpol = pol; t_cpha = pha;
    @(negedge clk_i);
  endtask

  task automatic set_reply(input int k, input logic [15:0] v, input int len, input bit lsb);
    for (int j = 0; j < len; j++) rep_bits[k*len + j] = v[lsb ? j : len-1-j];
  endtask

  function automatic logic [15:0] cap_word(input int k, input int len, input bit lsb);
    logic [15:0] w = '0;
    for (int j = 0; j < len; j++) w[lsb ? j : len-1-j] = cap_bits[k*len + j];
    return w;
  endfunction

  task automatic mon_clear();
    mon_cnt = 0; cs_low_cnt = 0; lead_cnt = 0; started = 0; edge_seen = 0;
    seen_mask = '0; sclk_prev = sclk; miso = rep_bits[0];
  endtask

  function automatic logic [31:0] txw(input logic [15:0] d, input int cs, input bit hold);
    return (32'(hold) << 28) | (32'(cs) << 16) | 32'(d);
  endfunction

  task automatic wait_release(input string tag);
    int n = 0;
    while (!(started && cs_n == csdef_exp) && n < 3000) begin @(negedge clk_i); n++; end
    chk(n < 3000, tag, 32'(n), 32'd3000);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(cs_n == 4'hF, "R1 cs idle", 32'(cs_n), 32'hF);
    chk(sclk == 1'b0 && mosi == 1'b0, "R1 sclk/mosi", {sclk, mosi}, 0);
    rd(3'd6, d);
    chk(d[31] == 1'b1 && d[29] == 1'b0, "R1 rx status", d, 32'h8000_0000);
    // R11: held in soft reset, a transmit write is dropped
    mon_clear();
    wr(3'd5, txw(16'h00AA, 0, 0));
    rd(3'd6, d);
    chk(d[29] == 1'b0, "R11 write ignored in reset", d, 0);
    wr(3'd0, 1); wr(3'd1, 32'h0100_0003);
    repeat (30) @(negedge clk_i);
    chk(!started && mon_cnt == 0, "R11 no activity", 32'(mon_cnt), 0);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    set_fmt(8, 3, 1, 0, 0);
    wr(3'd3, (32'd2 << 24) | (32'd3 << 16));
    set_reply(0, 16'h00A5, 8, 0);
    mon_clear();
    wr(3'd5, txw(16'h003C, 0, 0));
    wait_release("R4 release");
    chk(cap_word(0, 8, 0) == 16'h3C, "R2 mosi msb-first", 32'(cap_word(0, 8, 0)), 32'h3C);
    chk(cs_low_cnt == 37, "R4 cs low length", 32'(cs_low_cnt), 32'd37);
    chk(lead_cnt == 2, "R4 setup delay", 32'(lead_cnt), 32'd2);
    chk(sclk == 1'b0, "R3 idle low", 32'(sclk), 0);
    rd(3'd6, d);
    chk(d[15:0] == 16'hA5 && d[31] == 1'b0, "R5 rx posted", d, 32'h0000_00A5);
    rd(3'd6, d);
    chk(d[31] == 1'b1, "R5 read sets empty", d, 32'h8000_00A5);
  endtask

  task automatic t_lsb_mode2();
    logic [31:0] d;
    set_fmt(5, 1, 0, 1, 1);
    wr(3'd3, 0);
    chk(sclk == 1'b1, "R3 idle high with polarity", 32'(sclk), 1);
    set_reply(0, 16'h000B, 5, 1);
    mon_clear();
    wr(3'd5, txw(16'h0016, 0, 0));
    wait_release("R3 release");
    chk(cap_word(0, 5, 1) == 16'h16, "R3 lsb-first 5-bit", 32'(cap_word(0, 5, 1)), 32'h16);
    chk(cs_low_cnt == 10, "R4 zero delays", 32'(cs_low_cnt), 32'd10);
    rd(3'd6, d);
    chk(d[15:0] == 16'h0B, "R3 rx lsb-first", d, 32'h0B);
  endtask

  task automatic t_presc0();
    logic [31:0] d;
    set_fmt(8, 0, 0, 0, 0);
    wr(3'd3, (32'd1 << 24) | (32'd1 << 16));
    set_reply(0, 16'h007E, 8, 0);
    mon_clear();
    wr(3'd5, txw(16'h0081, 0, 0));
    wait_release("R3 presc0 release");
    chk(cs_low_cnt == 18, "R3 divisor 0 as 1", 32'(cs_low_cnt), 32'd18);
    chk(cap_word(0, 8, 0) == 16'h81, "R3 mode0 mosi", 32'(cap_word(0, 8, 0)), 32'h81);
    rd(3'd6, d);
    chk(d[15:0] == 16'h7E, "R3 mode0 rx", d, 32'h7E);
  endtask

  task automatic t_backtoback();
    logic [31:0] d;
    set_fmt(8, 3, 1, 0, 0);
    wr(3'd3, (32'd2 << 24) | (32'd3 << 16));
    set_reply(0, 16'h0055, 8, 0);
    set_reply(1, 16'h00C9, 8, 0);
    mon_clear();
    wr(3'd5, txw(16'h0011, 1, 1));
    repeat (3) @(negedge clk_i);
    wr(3'd5, txw(16'h0022, 1, 0));
    rd(3'd6, d);
    chk(d[29] == 1'b1, "R6 full while queued", d, 32'h2000_0000);
    wr(3'd5, txw(16'h0033, 1, 0));
    wait_release("R7 release");
    chk(mon_cnt == 16, "R6 third word dropped", 32'(mon_cnt), 32'd16);
    chk(cap_word(0, 8, 0) == 16'h11 && cap_word(1, 8, 0) == 16'h22, "R7 two words",
        {cap_word(0, 8, 0), cap_word(1, 8, 0)}, 32'h0011_0022);
    chk(cs_low_cnt == 69, "R7 no gap", 32'(cs_low_cnt), 32'd69);
    chk(seen_mask == 4'b0010, "R9 only line 1", 32'(seen_mask), 32'h2);
    rd(3'd6, d);
    chk(d[15:0] == 16'hC9, "R5 last rx wins", d, 32'hC9);
  endtask

  task automatic t_hold_end();
    logic [31:0] d;
    set_reply(0, 16'h0001, 8, 0);
    set_reply(1, 16'h0002, 8, 0);
    mon_clear();
    wr(3'd5, txw(16'h005A, 2, 1));
    repeat (80) @(negedge clk_i);
    chk(cs_n == 4'b1011, "R8 held low", 32'(cs_n), 32'hB);
    chk(mon_cnt == 8, "R8 first word done", 32'(mon_cnt), 32'd8);
    wr(3'd5, txw(16'h00C3, 2, 0));
    wait_release("R8 release");
    chk(cap_word(1, 8, 0) == 16'hC3, "R8 closing word", 32'(cap_word(1, 8, 0)), 32'hC3);
    rd(3'd6, d);
    chk(d[15:0] == 16'h02, "R8 rx", d, 32'h02);
  endtask

  task automatic t_csidle();
    wr(3'd4, 32'hD);
    csdef_exp = 4'b1101;
    chk(cs_n == 4'b1101, "R10 idle levels", 32'(cs_n), 32'hD);
    set_reply(0, 16'h0000, 8, 0);
    mon_clear();
    wr(3'd5, txw(16'h00F0, 3, 0));
    wait_release("R9 release");
    chk(seen_mask == 4'b1000, "R9 only line 3", 32'(seen_mask), 32'h8);
    chk(cs_n == 4'b1101, "R10 restored", 32'(cs_n), 32'hD);
    wr(3'd4, 32'hF);
    csdef_exp = 4'hF;
  endtask

  task automatic t_enable();
    logic [31:0] d;
    set_reply(0, 16'h0000, 8, 0);
    wr(3'd1, 32'h3);
    mon_clear();
    wr(3'd5, txw(16'h0096, 0, 0));
    repeat (20) @(negedge clk_i);
    chk(!started, "R12 waits when disabled", 32'(started), 0);
    rd(3'd6, d);
    chk(d[29] == 1'b1, "R12 still queued", d, 32'h2000_0000);
    wr(3'd1, 32'h0100_0003);
    wait_release("R12 release");
    chk(cap_word(0, 8, 0) == 16'h96, "R12 sent after enable", 32'(cap_word(0, 8, 0)), 32'h96);
    // R11: soft reset drops a queued word
    wr(3'd1, 32'h3);
    wr(3'd5, txw(16'h0069, 0, 0));
    wr(3'd0, 0);
    rd(3'd6, d);
    chk(d[29] == 1'b0 && d[31] == 1'b1, "R11 reset clears queue", d, 32'h8000_0000);
    wr(3'd0, 1); wr(3'd1, 32'h0100_0003);
    mon_clear();
    repeat (40) @(negedge clk_i);
    chk(!started, "R11 no stale word", 32'(started), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++; vectors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin rep_bits[i] = 1'b0; cap_bits[i] = 1'b0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_lsb_mode2();
    t_presc0();
    t_backtoback();
    t_hold_end();
    t_csidle();
    t_enable();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule